// File: doc/BRIEF.md
# FIFO Transit-Time Averaging Meter

This block estimates how long words spend inside a clock-domain-crossing FIFO. The write side of the FIFO raises a marker when it stores a tagged word. The read side raises a marker when that word comes out. Both markers come from clocks that are asynchronous to the meter. The meter brings both markers into a fast sampling clock through identical two-flop synchronizers, so the synchronizer delay cancels. It then counts the sampling cycles between the two rising edges.

A single measurement can only resolve whole sampling cycles. The phase between the FIFO clocks and the sampling clock drifts, so summing 256 measurements and shifting the sum right keeps fractional bits of the mean. The mean transit time is published on a 17-bit output with 8 fraction bits. A downstream consumer in another clock domain scales it to unit intervals. Publication uses a ready output and an acknowledge input that comes from the consumer's own clock.

Top module: `xfer_latency_meter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `avg_rdy_o` is 0 and `avg_o` is 0.
- R2: One measurement equals the number of sampling-clock cycles between the rising edge of `wr_mark_i` and the following rising edge of `rd_mark_i`. Both inputs pass through the same two-stage synchronizer. A read edge one cycle after the write edge gives 1.
- R3: A measurement saturates at 2^CNT_W-1 (511 with default parameters) and does not wrap.
- R4: A write-marker rise during an open measurement is ignored. A read-marker rise with no open measurement is ignored. Neither changes the published mean.
- R5: After 2^LOG2_N measurements (256 by default), the sum of the measurements shifted right by LOG2_N-FRAC_W becomes the new mean. With default parameters this is the raw sum: bits 16:8 are whole sampling cycles and bits 7:0 are 1/256 fractions of a cycle.
- R6: When a mean is published, `avg_rdy_o` rises together with the new `avg_o`. Both hold steady until the synchronized acknowledge is seen.
- R7: `avg_ack_i` passes through a two-flop synchronizer. `avg_rdy_o` falls on the third sampling edge after `avg_ack_i` rises.
- R8: A batch that completes while `avg_rdy_o` is high, or while the synchronized acknowledge is still high, is discarded. A new mean is published only from a batch that completes after the acknowledge has returned low.
- R9: Reset clears the running sum and the measurement count. A batch begun before reset does not contribute to the next mean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hs_clk | input | 1 | Sampling clock, faster than and asynchronous to both FIFO clocks |
| hs_rst | input | 1 | Synchronous active-high reset in the sampling domain |
| wr_mark_i | input | 1 | Write-side marker, asynchronous level, rising edge opens a measurement |
| rd_mark_i | input | 1 | Read-side marker, asynchronous level, rising edge closes a measurement |
| avg_ack_i | input | 1 | Acknowledge from the consumer's clock domain |
| avg_o | output | 17 (CNT_W+FRAC_W) | Mean transit time in sampling cycles, FRAC_W fraction bits |
| avg_rdy_o | output | 1 | High while a published mean awaits acknowledge |

## Verification
The properties assume that each marker stays high for at least two sampling cycles, so that every rise is seen. They also assume that the consumer keeps acknowledge high until ready has fallen. The stimulus drives both markers as two-cycle pulses on the falling sampling edge. It holds acknowledge for three or more cycles and returns it low before the next batch completes, except in the deliberate discard cases. Read pulses in idle and extra write pulses during a measurement are spaced so that they land entirely within the idle or open phase they are meant to probe.

// File: rtl/meter_pkg.sv
package meter_pkg;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_RUN  = 1'b1
    } meas_st_e;

    typedef enum logic {
        HO_IDLE = 1'b0,
        HO_FULL = 1'b1
    } ho_st_e;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/mark_sync.sv
module mark_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mark_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     lvl;

    level_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (mark_i),
        .sync_o  (lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise_o = lvl & ~st_q.prev;
endmodule

// File: rtl/transit_counter.sv
module transit_counter
    import meter_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] sample_o,
    output logic             sample_vld_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        meas_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] smp;
        logic             vld;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.st)
            MS_IDLE: begin
                if (start_i) begin
                    st_d.st  = MS_RUN;
                    st_d.cnt = CNT_W'(1);
                end
            end
            MS_RUN: begin
                if (stop_i) begin
                    st_d.st  = MS_IDLE;
                    st_d.vld = 1'b1;
                    st_d.smp = st_q.cnt;
                end else if (st_q.cnt != CNT_MAX) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.st = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sample_o     = st_q.smp;
    assign sample_vld_o = st_q.vld;
    assign run_o        = (st_q.st == MS_RUN);
    assign cnt_o        = st_q.cnt;
endmodule

// File: rtl/batch_accum.sv
module batch_accum #(
    parameter int CNT_W  = 9,
    parameter int LOG2_N = 8,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        sample_i,
    input  logic                    sample_vld_i,
    output logic                    done_o,
    output logic [CNT_W+FRAC_W-1:0] mean_o
);
    localparam int SUM_W = CNT_W + LOG2_N;
    localparam int RES_W = CNT_W + FRAC_W;
    localparam int SHIFT = LOG2_N - FRAC_W;
    localparam logic [LOG2_N-1:0] LAST = {LOG2_N{1'b1}};

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [LOG2_N-1:0] n;
        logic              done;
        logic [RES_W-1:0]  mean;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [SUM_W-1:0] total;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        total     = st_q.sum + SUM_W'(sample_i);
        if (sample_vld_i) begin
            if (st_q.n == LAST) begin
                st_d.mean = RES_W'(total >> SHIFT);
                st_d.done = 1'b1;
                st_d.sum  = '0;
                st_d.n    = '0;
            end else begin
                st_d.sum  = total;
                st_d.n    = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign mean_o = st_q.mean;
endmodule

// File: rtl/result_handoff.sv
module result_handoff
    import meter_pkg::*;
#(
    parameter int RES_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic [RES_W-1:0] mean_i,
    input  logic             ack_sync_i,
    output logic             ready_o,
    output logic [RES_W-1:0] value_o
);
    typedef struct packed {
        ho_st_e           st;
        logic [RES_W-1:0] val;
    } ho_t;

    ho_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            HO_IDLE: begin
                if (done_i && !ack_sync_i) begin
                    st_d.st  = HO_FULL;
                    st_d.val = mean_i;
                end
            end
            HO_FULL: begin
                if (ack_sync_i) st_d.st = HO_IDLE;
            end
            default: st_d.st = HO_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ready_o = (st_q.st == HO_FULL);
    assign value_o = st_q.val;
endmodule

// File: rtl/xfer_latency_meter.sv
module xfer_latency_meter #(
    parameter int CNT_W       = 9,
    parameter int LOG2_N      = 8,
    parameter int FRAC_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int RES_W      = CNT_W + FRAC_W
) (
    input  logic             hs_clk,
    input  logic             hs_rst,
    input  logic             wr_mark_i,
    input  logic             rd_mark_i,
    input  logic             avg_ack_i,
    output logic [RES_W-1:0] avg_o,
    output logic             avg_rdy_o
);
    logic             wr_rise;
    logic             rd_rise;
    logic             ack_sync;
    logic [CNT_W-1:0] sample;
    logic             sample_vld;
    logic             meas_run;
    logic [CNT_W-1:0] meas_cnt;
    logic             batch_done;
    logic [RES_W-1:0] batch_mean;

    mark_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk    (hs_clk),
        .rst    (hs_rst),
        .mark_i (wr_mark_i),
        .rise_o (wr_rise)
    );

    mark_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk    (hs_clk),
        .rst    (hs_rst),
        .mark_i (rd_mark_i),
        .rise_o (rd_rise)
    );

    level_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (hs_clk),
        .rst     (hs_rst),
        .async_i (avg_ack_i),
        .sync_o  (ack_sync)
    );

    transit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (hs_clk),
        .rst          (hs_rst),
        .start_i      (wr_rise),
        .stop_i       (rd_rise),
        .sample_o     (sample),
        .sample_vld_o (sample_vld),
        .run_o        (meas_run),
        .cnt_o        (meas_cnt)
    );

    batch_accum #(.CNT_W(CNT_W), .LOG2_N(LOG2_N), .FRAC_W(FRAC_W)) u_acc (
        .clk          (hs_clk),
        .rst          (hs_rst),
        .sample_i     (sample),
        .sample_vld_i (sample_vld),
        .done_o       (batch_done),
        .mean_o       (batch_mean)
    );

    result_handoff #(.RES_W(RES_W)) u_ho (
        .clk        (hs_clk),
        .rst        (hs_rst),
        .done_i     (batch_done),
        .mean_i     (batch_mean),
        .ack_sync_i (ack_sync),
        .ready_o    (avg_rdy_o),
        .value_o    (avg_o)
    );
endmodule

// File: rtl/meter_chk.sv
module meter_chk #(
    parameter int CNT_W = 9,
    parameter int RES_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             ready,
    input logic [RES_W-1:0] value,
    input logic             ack_s,
    input logic             running,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!ready && value == '0));

    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        (running && cnt != CMAX) |=> (!running || cnt == $past(cnt) + 1'b1));

    a_r3_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (running && cnt == CMAX) |=> (cnt == CMAX));

    a_r6_value_held: assert property (@(posedge clk) disable iff (rst)
        (ready && !ack_s) |=> (ready && $stable(value)));

    a_r7_ready_released: assert property (@(posedge clk) disable iff (rst)
        (ready && ack_s) |=> !ready);

    a_r8_no_publish_under_ack: assert property (@(posedge clk) disable iff (rst)
        (!ready && ack_s) |=> !ready);
endmodule

bind xfer_latency_meter meter_chk #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
    .clk     (hs_clk),
    .rst     (hs_rst),
    .ready   (avg_rdy_o),
    .value   (avg_o),
    .ack_s   (ack_sync),
    .running (meas_run),
    .cnt     (meas_cnt)
);

// File: tb/sim_xfer_latency_meter.sv
`timescale 1ns/1ps
module sim_xfer_latency_meter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr  = 1'b0;
    logic        rd  = 1'b0;
    logic        ack = 1'b0;
    logic [16:0] avg;
    logic        rdy;
    int          n_chk  = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    xfer_latency_meter u0 (
        .hs_clk    (clk),
        .hs_rst    (rst),
        .wr_mark_i (wr),
        .rd_mark_i (rd),
        .avg_ack_i (ack),
        .avg_o     (avg),
        .avg_rdy_o (rdy)
    );

    // delay for even-index measurements, odd-index, extra markers, expected mean
    localparam int NV = 5;
    localparam int VEC [NV][4] = '{
        '{3,  3,  0, 768},
        '{4,  5,  0, 1152},
        '{10, 12, 0, 2816},
        '{1,  2,  0, 384},
        '{8,  8,  1, 2048}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic meas(input int d, input bit extra);
        if (extra) begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                rd = (i < 2);
            end
        end
        for (int i = 0; i < d + 4; i++) begin
            @(negedge clk);
            wr = (i < 2) || (extra && (i == 3 || i == 4));
            rd = (i >= d) && (i < d + 2);
        end
    endtask

    task automatic batch(input int a, input int b, input bit extra);
        for (int k = 0; k < 256; k++) meas((k % 2 == 1) ? b : a, extra);
    endtask

    task automatic wait_ready(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            if (rdy) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // ack timing: ready high two edges after ack, low on the third
    task automatic ack_cycle(input string req);
        @(negedge clk);
        ack = 1'b1;
        tick(2);
        chk(req, int'(rdy), 1);
        tick(1);
        chk(req, int'(rdy), 0);
        ack = 1'b0;
        tick(4);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        tick(3);
        chk("R1 ready in reset", int'(rdy), 0);
        chk("R1 value in reset", int'(avg), 0);
        rst = 1'b0;
        tick(1);
        chk("R1 ready after reset", int'(rdy), 0);

        // R2 R5 R6 R7 (and R4 on the entry with extra markers)
        for (int v = 0; v < NV; v++) begin
            batch(VEC[v][0], VEC[v][1], VEC[v][2] != 0);
            wait_ready(seen);
            chk("R6 ready published", int'(seen), 1);
            chk((VEC[v][2] != 0) ? "R4 stray markers ignored" : "R5 mean R2 count",
                int'(avg), VEC[v][3]);
            ack_cycle("R7 ack sync timing");
        end

        // R8: batch completing while ready still high is discarded
        batch(4, 5, 0);
        wait_ready(seen);
        chk("R6 ready for drop test", int'(seen), 1);
        batch(2, 2, 0);
        tick(10);
        chk("R8 ready held while busy", int'(rdy), 1);
        chk("R8 value kept while busy", int'(avg), 1152);
        ack_cycle("R7 ack after drop");

        // R8: batch completing under a held acknowledge is discarded
        ack = 1'b1;
        tick(4);
        batch(1, 1, 0);
        tick(10);
        chk("R8 no publish under ack", int'(rdy), 0);
        ack = 1'b0;
        tick(10);
        chk("R8 dropped batch stays dropped", int'(rdy), 0);
        batch(6, 6, 0);
        wait_ready(seen);
        chk("R8 later batch publishes", int'(avg), 1536);
        ack_cycle("R7 ack after later batch");

        // R9: partial batch before reset does not contribute
        for (int k = 0; k < 100; k++) meas(3, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(2);
        batch(2, 2, 0);
        wait_ready(seen);
        chk("R9 sum cleared by reset", int'(avg), 512);
        ack_cycle("R7 ack after reset batch");

        // R3: counts saturate at 511
        batch(512, 512, 0);
        wait_ready(seen);
        chk("R3 saturated mean", int'(avg), 130816);
        ack_cycle("R7 ack after saturation");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule